// File: doc/BRIEF.md
# Interrupt Status and Enable Unit for a Serial Port

This block gathers the event indications of a serial port's receive and transmit paths into one status register and raises a single interrupt line. Four sources are sticky. Transmit request, framing error, break and receive overrun each latch on a one-cycle event pulse and stay set until software clears them. Two sources are live levels: the receive trigger and the receive timeout follow the receive FIFO condition as it is now. Software clears sticky bits by writing ones to the status register. It can also force a transmit request by writing a one to a dedicated bit of that register.

A control register holds three enables. The first gates the transmit request. The second gates both receive levels. The third covers all three error sources at once. The interrupt output is the registered OR of every enabled status bit. Access uses a plain register bus: select, write, word address, write data, and combinational read data.

Top module: `uart_irq_status`

## Requirements
- R1: After reset the status register and the control register both read 0x00, and `irqOut` is low.
- R2: Status bit 0 (transmit request), bit 3 (framing error), bit 4 (break) and bit 5 (receive overrun) set on a one-cycle pulse of their event inputs. They stay set over later cycles when nothing clears them.
- R3: A write to the status register (word address 0) clears each sticky bit whose write-data bit is 1. A write data bit of 0 leaves the matching bit unchanged.
- R4: Status bit 1 always reads the present value of `lvlRxTrig`, and status bit 2 always reads the present value of `lvlRxTimeout`. Writes to the status register do not change either bit.
- R5: When an event pulse and a clearing write hit the same sticky bit in the same cycle, the bit ends up set.
- R6: Writing a 1 to status bit 6 sets status bit 0. Status bit 6 always reads 0.
- R7: The control register (word address 1) keeps write-data bits 5 (transmit enable), 6 (receive enable) and 7 (error enable). Its other bits read 0. A read of any other address returns 0.
- R8: `irqOut` is high in cycle n+1 exactly when, in cycle n, one of these holds: bit 0 is set with the transmit enable on; bit 1 or bit 2 is set with the receive enable on; or bit 3, 4 or 5 is set with the error enable on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Word address (0 status, 1 control) |
| busWdata | input | BUS_W | Write data |
| busRdata | output | BUS_W | Read data of the addressed register (combinational) |
| evTxReq | input | 1 | Transmit request event pulse |
| evFrameErr | input | 1 | Framing error event pulse |
| evBreak | input | 1 | Break detected event pulse |
| evOverrun | input | 1 | Receive overrun event pulse |
| lvlRxTrig | input | 1 | Receive FIFO at or above its trigger level |
| lvlRxTimeout | input | 1 | Receive inactivity timeout condition |
| irqOut | output | 1 | Registered interrupt request |

## Verification
The bench aims at the ambiguous corners of the status register. Several cases are covered:
- A write of zeros must leave all bits alone. A design that treated the write as a plain store would wipe pending events.
- Level bits must ignore clearing writes. A design that latched them would report a stale receive condition.
- An event pulse landing on the same cycle as its clear must survive. A design that favoured the write would lose that event.
- The transmit-set bit must raise bit 0 while it reads back as zero.

The interrupt is probed on the cycle right after an event and on the cycle after that, which exposes a missing or doubled pipeline stage. It is also probed with each enable group in turn, which catches sources wired to the wrong enable.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int NUM_SRC = 7;

  // status bit positions (software-visible)
  localparam int B_TX     = 0;
  localparam int B_RXTRIG = 1;
  localparam int B_RXTMO  = 2;
  localparam int B_FRM    = 3;
  localparam int B_BRK    = 4;
  localparam int B_OVR    = 5;
  localparam int B_TXSET  = 6;

  localparam logic [NUM_SRC-1:0] STICKY_MASK =
    NUM_SRC'((1 << B_TX) | (1 << B_FRM) | (1 << B_BRK) | (1 << B_OVR));
  localparam logic [NUM_SRC-1:0] LEVEL_MASK =
    NUM_SRC'((1 << B_RXTRIG) | (1 << B_RXTMO));
  localparam logic [NUM_SRC-1:0] ERR_MASK =
    NUM_SRC'((1 << B_FRM) | (1 << B_BRK) | (1 << B_OVR));

  // control register enable field
  localparam int EN_LSB = 5;
  localparam int NUM_EN = 3;
  localparam int E_TX   = 0;
  localparam int E_RX   = 1;
  localparam int E_ERR  = 2;

  typedef struct packed {
    logic                 stWrite;
    logic                 ctlWrite;
    logic [NUM_SRC-1:0]   clrMask;
    logic                 swSetTx;
    logic [NUM_EN-1:0]    enData;
  } regStrobe_t;
endpackage

// File: rtl/irq_stat_ctl.sv
module irq_stat_ctl
  import irq_stat_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int ADDR_W = 2,
  parameter logic [ADDR_W-1:0] ST_ADDR = 0,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  output regStrobe_t        stb
);
  logic hitSt;
  logic hitCtl;

  always_comb begin
    hitSt  = busSel && busWrite && (busAddr == ST_ADDR);
    hitCtl = busSel && busWrite && (busAddr == CTL_ADDR);
    stb.stWrite  = hitSt;
    stb.ctlWrite = hitCtl;
    stb.clrMask  = hitSt ? (busWdata[NUM_SRC-1:0] & STICKY_MASK) : '0;
    stb.swSetTx  = hitSt && busWdata[B_TXSET];
    stb.enData   = busWdata[EN_LSB +: NUM_EN];
  end

  // R3/R7: a bus write targets at most one register
  p_one_target_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.stWrite, stb.ctlWrite}));

  // R3: clear strobes only come from a status write
  p_clear_src_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrMask != '0) |-> stb.stWrite);
endmodule

// File: rtl/irq_stat_dp.sv
module irq_stat_dp
  import irq_stat_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int ADDR_W = 2,
  parameter logic [ADDR_W-1:0] ST_ADDR = 0,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobe_t         stb,
  input  logic [NUM_SRC-1:0] evVec,
  input  logic [NUM_SRC-1:0] lvlVec,
  input  logic [ADDR_W-1:0]  busAddr,
  output logic [BUS_W-1:0]   busRdata,
  output logic               irqOut
);
  localparam int PAD_ST  = BUS_W - NUM_SRC;
  localparam int PAD_CTL = BUS_W - EN_LSB - NUM_EN;

  logic [NUM_SRC-1:0] stickyQ;
  logic [NUM_SRC-1:0] stickyNext;
  logic [NUM_SRC-1:0] setVec;
  logic [NUM_SRC-1:0] status;
  logic [NUM_EN-1:0]  enQ;
  logic               irqNext;

  always_comb begin
    setVec = '0;
    setVec[B_TX] = stb.swSetTx;
    // event and software set are applied after the clear: event wins
    stickyNext = ((stickyQ & ~stb.clrMask) | evVec | setVec) & STICKY_MASK;
    status = (stickyQ & STICKY_MASK) | (lvlVec & LEVEL_MASK);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stickyQ <= '0;
      enQ     <= '0;
      irqOut  <= 1'b0;
    end else begin
      stickyQ <= stickyNext;
      if (stb.ctlWrite) enQ <= stb.enData;
      irqOut <= irqNext;
    end
  end

  always_comb begin
    irqNext = (enQ[E_TX]  && status[B_TX])
           || (enQ[E_RX]  && |(status & LEVEL_MASK))
           || (enQ[E_ERR] && |(status & ERR_MASK));
  end

  always_comb begin
    if (busAddr == ST_ADDR)
      busRdata = {{PAD_ST{1'b0}}, status};
    else if (busAddr == CTL_ADDR)
      busRdata = {{PAD_CTL{1'b0}}, enQ, {EN_LSB{1'b0}}};
    else
      busRdata = '0;
  end

  // per-source checks on the sticky bits
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (STICKY_MASK[i]) begin : g_sticky
      p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
        (stickyQ[i] && !stb.clrMask[i]) |=> stickyQ[i]);
      p_event_wins_r5: assert property (@(posedge clk) disable iff (!rstN)
        evVec[i] |=> stickyQ[i]);
      p_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
        (stb.clrMask[i] && !evVec[i] && !setVec[i]) |=> !stickyQ[i]);
    end
  end

  p_irq_tx_r8: assert property (@(posedge clk) disable iff (!rstN)
    (enQ[E_TX] && stickyQ[B_TX]) |=> irqOut);
  p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (enQ == '0) |=> !irqOut);
  p_txset_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.swSetTx |=> stickyQ[B_TX]);
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
  import irq_stat_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  input  logic              evTxReq,
  input  logic              evFrameErr,
  input  logic              evBreak,
  input  logic              evOverrun,
  input  logic              lvlRxTrig,
  input  logic              lvlRxTimeout,
  output logic              irqOut
);
  localparam logic [ADDR_W-1:0] ST_ADDR  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(1);

  regStrobe_t         stb;
  logic [NUM_SRC-1:0] evVec;
  logic [NUM_SRC-1:0] lvlVec;

  always_comb begin
    evVec = '0;
    evVec[B_TX]  = evTxReq;
    evVec[B_FRM] = evFrameErr;
    evVec[B_BRK] = evBreak;
    evVec[B_OVR] = evOverrun;
    lvlVec = '0;
    lvlVec[B_RXTRIG] = lvlRxTrig;
    lvlVec[B_RXTMO]  = lvlRxTimeout;
  end

  irq_stat_ctl #(
    .BUS_W(BUS_W), .ADDR_W(ADDR_W), .ST_ADDR(ST_ADDR), .CTL_ADDR(CTL_ADDR)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .stb(stb)
  );

  irq_stat_dp #(
    .BUS_W(BUS_W), .ADDR_W(ADDR_W), .ST_ADDR(ST_ADDR), .CTL_ADDR(CTL_ADDR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .evVec(evVec), .lvlVec(lvlVec),
    .busAddr(busAddr), .busRdata(busRdata), .irqOut(irqOut)
  );
endmodule

// File: tb/test_uart_irq_status.sv
module test_uart_irq_status;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busSel = 1'b0;
  logic       busWrite = 1'b0;
  logic [1:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic evTxReq = 1'b0, evFrameErr = 1'b0, evBreak = 1'b0, evOverrun = 1'b0;
  logic lvlRxTrig = 1'b0, lvlRxTimeout = 1'b0;
  logic irqOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic rdProbe = 1'b0;
  logic irqProbe = 1'b0;
  logic [7:0] rdQ[$];
  string      rdTagQ[$];
  logic       irqQ[$];
  string      irqTagQ[$];

  always #10 clk = ~clk;  // 50 MHz

  uart_irq_status i_uart_irq_status (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .evTxReq(evTxReq), .evFrameErr(evFrameErr), .evBreak(evBreak),
    .evOverrun(evOverrun), .lvlRxTrig(lvlRxTrig), .lvlRxTimeout(lvlRxTimeout),
    .irqOut(irqOut)
  );

  // monitor: compares design outputs against the scoreboard queues
  always @(negedge clk) begin
    if (rdProbe && rdQ.size() > 0) begin
      logic [7:0] e;
      string t;
      e = rdQ.pop_front();
      t = rdTagQ.pop_front();
      checks++;
      if (busRdata !== e) begin
        errors++;
        $display("FAIL %s: read data %h expected %h", t, busRdata, e);
      end
    end
    if (irqProbe && irqQ.size() > 0) begin
      logic e;
      string t;
      e = irqQ.pop_front();
      t = irqTagQ.pop_front();
      checks++;
      if (irqOut !== e) begin
        errors++;
        $display("FAIL %s: irqOut %b expected %b", t, irqOut, e);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    step();
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, input logic [7:0] e, input string t);
    rdQ.push_back(e); rdTagQ.push_back(t);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a; rdProbe = 1'b1;
    step();
    busSel = 1'b0; rdProbe = 1'b0;
  endtask

  task automatic irqCheck(input logic e, input string t);
    irqQ.push_back(e); irqTagQ.push_back(t);
    irqProbe = 1'b1;
    step();
    irqProbe = 1'b0;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    step();
    // R1: reset state
    regRead(2'd0, 8'h00, "R1 status after reset");
    regRead(2'd1, 8'h00, "R1 control after reset");
    irqCheck(1'b0, "R1 irq after reset");

    // R2: break and framing pulses latch
    evBreak = 1'b1; evFrameErr = 1'b1;
    step();
    evBreak = 1'b0; evFrameErr = 1'b0;
    regRead(2'd0, 8'h18, "R2 latch break+frame");
    repeat (4) step();
    regRead(2'd0, 8'h18, "R2 bits hold");

    // R3: write-one-to-clear, zeros leave bits unchanged
    regWrite(2'd0, 8'h08);
    regRead(2'd0, 8'h10, "R3 clear framing only");
    regWrite(2'd0, 8'h00);
    regRead(2'd0, 8'h10, "R3 zero write keeps break");

    // R4: live level bits ignore writes
    lvlRxTrig = 1'b1;
    step();
    regRead(2'd0, 8'h12, "R4 trigger level visible");
    regWrite(2'd0, 8'h06);
    regRead(2'd0, 8'h12, "R4 trigger not cleared by write");
    lvlRxTrig = 1'b0; lvlRxTimeout = 1'b1;
    regRead(2'd0, 8'h14, "R4 timeout level follows input");

    // R5: event and clear in the same cycle -> event wins
    evOverrun = 1'b1;
    regWrite(2'd0, 8'h20);
    evOverrun = 1'b0;
    regRead(2'd0, 8'h34, "R5 overrun survives clear");
    regWrite(2'd0, 8'h30);
    regRead(2'd0, 8'h04, "R3 clear overrun+break");

    // R6: software transmit set
    regWrite(2'd0, 8'h40);
    regRead(2'd0, 8'h05, "R6 bit6 sets bit0, reads 0");

    // R7: control register enables
    regWrite(2'd1, 8'hFF);
    regRead(2'd1, 8'hE0, "R7 control keeps bits 7:5");
    regRead(2'd2, 8'h00, "R7 unmapped address reads 0");

    // R8: gating per enable group
    step();
    irqCheck(1'b1, "R8 all enables, tx+timeout pending");
    regWrite(2'd1, 8'h40);
    step();
    irqCheck(1'b1, "R8 rx enable with timeout level");
    lvlRxTimeout = 1'b0;
    step(); step();
    irqCheck(1'b0, "R8 tx pending but tx disabled");
    regWrite(2'd1, 8'h20);
    step();
    irqCheck(1'b1, "R8 tx enable with tx pending");
    regWrite(2'd1, 8'h80);
    regWrite(2'd0, 8'h3F);
    step(); step();
    irqCheck(1'b0, "R8 error enable, nothing pending");
    evOverrun = 1'b1;
    step();
    evOverrun = 1'b0;
    irqCheck(1'b0, "R8 one-cycle latency, not yet high");
    irqCheck(1'b1, "R8 overrun raises irq after register");
    regWrite(2'd0, 8'h20);
    step();
    irqCheck(1'b0, "R8 irq drops after clear");
    regRead(2'd0, 8'h00, "R3 all cleared");

    step();
    finishRun();
  end
endmodule